// File: doc/BRIEF.md
# Banked Register File Address Generator

This block forms the 9-bit data-memory address for a small 8-bit controller core whose register file is split into four banks of 128 locations. Each access is one of two kinds. A direct access joins the 7-bit register field from the instruction with the two bank-select bits held in the status register. An access to register field 00h is an indirect access. It uses the 8-bit pointer register together with a separate pointer-bank bit in the status register.

The block holds the status register and the pointer register itself. It decodes them at their fixed offsets in every bank, and it applies bus writes to them. It returns read data for them, and it returns RAM data for every other location. The offsets 02h, 0Ah and 0Bh name shared registers that have one physical copy each. For these offsets the RAM address is always forced into bank 0. An indirect access whose target is the pointer pseudo-register itself is treated as a null access. The ALU, the instruction decoder and the RAM array are outside this block.

Top module: `bank_addr_gen`

## Requirements
- R1: When `fld_i` is not 00h, the address is {STATUS[6:5], fld_i}, unless R6 folds it.
- R2: When `fld_i` is 00h, the address is {STATUS[7], pointer[7:0]}, unless R6 folds it.
- R3: An indirect access whose target low 7 bits are 00h reads 00h and never asserts `ram_we_o`.
- R4: A target whose low 7 bits are 03h reaches STATUS and 04h reaches the pointer register, in every bank and also through the pointer. Such accesses never assert `ram_we_o`.
- R5: STATUS reads as {ptr_bank, bank[1:0], pwr_flags_i[1], pwr_flags_i[0], z, dc, c} with bit 7 first. Writes update bits 7:5 and 2:0. Bits 4:3 always show `pwr_flags_i` and ignore writes.
- R6: A target whose low 7 bits are 02h, 03h, 04h, 0Ah or 0Bh is given a RAM address in bank 0, with bits 8:7 equal to 00.
- R7: After reset, STATUS bits 7:5 and 2:0 are 0 and the pointer register is 00h, so bank 0 is selected.
- R8: `ram_we_o` is high only when both `acc_i` and `we_i` are high and the target is an ordinary RAM location.
- R9: For an ordinary RAM target, `rdata_o` equals `ram_rdata_i`.
- R10: STATUS and the pointer register change only on a clock edge where both `acc_i` and `we_i` are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | Register access strobe for this cycle |
| fld_i | input | 7 | Register field from the instruction |
| we_i | input | 1 | Write enable for the access |
| wdata_i | input | 8 | Write data |
| pwr_flags_i | input | 2 | Read-only timeout flag (bit 1) and power-down flag (bit 0) |
| ram_rdata_i | input | 8 | Data read from RAM at `ram_addr_o` |
| ram_addr_o | output | 9 | Effective RAM address |
| ram_we_o | output | 1 | RAM write strobe |
| rdata_o | output | 8 | Read data for the access |

## Verification
Direct accesses are run in all four banks with the same register field. This shows whether both bank bits reach the address and whether they reach it in the right order. Indirect accesses are run with the pointer bank bit set and cleared, and with pointers whose low seven bits are zero. These cases separate a plain pointer pass-through from the null rule. The status and pointer offsets and the shared offsets are reached from high banks and through the pointer, which shows that folding depends on the effective target and not on the bank. Writes with the strobe or the write enable low, and writes of all ones to the status register, show which state must stay unchanged.

// File: rtl/bag_pkg.sv
package bag_pkg;
  localparam int FLD_W  = 7;
  localparam int DAT_W  = 8;
  localparam int BANK_W = 2;
  localparam int ADR_W  = FLD_W + BANK_W;

  localparam logic [FLD_W-1:0] OFS_INDF   = 7'h00;
  localparam logic [FLD_W-1:0] OFS_STATUS = 7'h03;
  localparam logic [FLD_W-1:0] OFS_FSR    = 7'h04;

  // single-copy registers folded into bank 0 (besides status/pointer)
  localparam int NUM_SHARED = 3;
  localparam logic [FLD_W-1:0] SHARED_OFS [NUM_SHARED] = '{7'h02, 7'h0A, 7'h0B};

  typedef struct packed {
    logic              irp;
    logic [BANK_W-1:0] rp;
    logic              z;
    logic              dc;
    logic              c;
  } stat_t;
endpackage

// File: rtl/bag_addr_mux.sv
module bag_addr_mux
  import bag_pkg::*;
#(
  parameter int FW = FLD_W,
  parameter int DW = DAT_W,
  parameter int BW = BANK_W,
  localparam int AW = FW + BW
) (
  input  logic [FW-1:0] fld_i,
  input  logic [BW-1:0] rp_i,
  input  logic          irp_i,
  input  logic [DW-1:0] ptr_i,
  output logic [AW-1:0] eff_o,
  output logic          ind_o
);
  assign ind_o = (fld_i == OFS_INDF);

  always_comb begin
    if (ind_o) eff_o = {irp_i, ptr_i};
    else       eff_o = {rp_i, fld_i};
  end
endmodule

// File: rtl/bag_target_dec.sv
module bag_target_dec
  import bag_pkg::*;
#(
  parameter int FW = FLD_W,
  parameter int BW = BANK_W,
  localparam int AW = FW + BW
) (
  input  logic [AW-1:0] eff_i,
  input  logic          ind_i,
  output logic          hit_status_o,
  output logic          hit_ptr_o,
  output logic          null_o,
  output logic [AW-1:0] ram_addr_o
);
  logic [FW-1:0]         lo;
  logic [NUM_SHARED-1:0] sh_match;
  logic                  fold;

  assign lo = eff_i[FW-1:0];

  for (genvar i = 0; i < NUM_SHARED; i++) begin : g_sh
    assign sh_match[i] = (lo == SHARED_OFS[i]);
  end

  assign hit_status_o = (lo == OFS_STATUS);
  assign hit_ptr_o    = (lo == OFS_FSR);
  assign null_o       = ind_i && (lo == OFS_INDF);
  assign fold         = (|sh_match) || hit_status_o || hit_ptr_o;
  assign ram_addr_o   = fold ? {{BW{1'b0}}, lo} : eff_i;
endmodule

// File: rtl/bag_core_regs.sv
module bag_core_regs
  import bag_pkg::*;
#(
  parameter int DW = DAT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_status_i,
  input  logic          wr_ptr_i,
  input  logic [DW-1:0] wdata_i,
  output stat_t         stat_o,
  output logic [DW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= '0;
      ptr_o  <= '0;
    end else begin
      if (wr_status_i) begin
        stat_o.irp <= wdata_i[7];
        stat_o.rp  <= wdata_i[6:5];
        stat_o.z   <= wdata_i[2];
        stat_o.dc  <= wdata_i[1];
        stat_o.c   <= wdata_i[0];
      end
      if (wr_ptr_i) ptr_o <= wdata_i;
    end
  end
endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
  import bag_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic [FLD_W-1:0] fld_i,
  input  logic             we_i,
  input  logic [DAT_W-1:0] wdata_i,
  input  logic [1:0]       pwr_flags_i,
  input  logic [DAT_W-1:0] ram_rdata_i,
  output logic [ADR_W-1:0] ram_addr_o,
  output logic             ram_we_o,
  output logic [DAT_W-1:0] rdata_o
);
  stat_t            status_q;
  logic [DAT_W-1:0] fsr_q;
  logic [ADR_W-1:0] eff;
  logic             ind, hit_status, hit_ptr, null_acc, wr;
  logic [DAT_W-1:0] status_rd;

  bag_addr_mux #(.FW(FLD_W), .DW(DAT_W), .BW(BANK_W)) u_mux (
    .fld_i (fld_i),
    .rp_i  (status_q.rp),
    .irp_i (status_q.irp),
    .ptr_i (fsr_q),
    .eff_o (eff),
    .ind_o (ind)
  );

  bag_target_dec #(.FW(FLD_W), .BW(BANK_W)) u_dec (
    .eff_i        (eff),
    .ind_i        (ind),
    .hit_status_o (hit_status),
    .hit_ptr_o    (hit_ptr),
    .null_o       (null_acc),
    .ram_addr_o   (ram_addr_o)
  );

  assign wr = acc_i && we_i;

  bag_core_regs #(.DW(DAT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_status_i (wr && hit_status),
    .wr_ptr_i    (wr && hit_ptr),
    .wdata_i     (wdata_i),
    .stat_o      (status_q),
    .ptr_o       (fsr_q)
  );

  assign status_rd = {status_q.irp, status_q.rp, pwr_flags_i,
                      status_q.z, status_q.dc, status_q.c};

  assign ram_we_o = wr && !hit_status && !hit_ptr && !null_acc;

  always_comb begin
    if (hit_status)    rdata_o = status_rd;
    else if (hit_ptr)  rdata_o = fsr_q;
    else if (null_acc) rdata_o = '0;
    else               rdata_o = ram_rdata_i;
  end
endmodule

// File: rtl/bank_addr_gen_chk.sv
module bank_addr_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       acc_i,
  input logic       we_i,
  input logic [6:0] fld_i,
  input logic [1:0] pwr_flags_i,
  input logic [8:0] ram_addr_o,
  input logic       ram_we_o,
  input logic [7:0] rdata_o,
  input logic [7:0] fsr_q
);
  // R1
  direct_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fld_i != 7'h00) |-> (ram_addr_o[6:0] == fld_i));

  // R2
  indirect_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fld_i == 7'h00) |-> (ram_addr_o[6:0] == fsr_q[6:0]));

  // R3
  null_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_addr_o[6:0] == 7'h00) |-> (rdata_o == 8'h00 && !ram_we_o));

  // R4
  core_no_ram_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_addr_o[6:0] != 7'h03 && ram_addr_o[6:0] != 7'h04));

  // R5
  ro_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_addr_o[6:0] == 7'h03) |-> (rdata_o[4:3] == pwr_flags_i));

  // R6
  shared_fold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_addr_o[6:0] == 7'h02 || ram_addr_o[6:0] == 7'h0A ||
     ram_addr_o[6:0] == 7'h0B) |-> (ram_addr_o[8:7] == 2'b00));

  // R8
  ram_we_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (acc_i && we_i));

  // R10
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_i && we_i) |=> $stable(fsr_q));
endmodule

bind bank_addr_gen bank_addr_gen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_i       (acc_i),
  .we_i        (we_i),
  .fld_i       (fld_i),
  .pwr_flags_i (pwr_flags_i),
  .ram_addr_o  (ram_addr_o),
  .ram_we_o    (ram_we_o),
  .rdata_o     (rdata_o),
  .fsr_q       (fsr_q)
);

// File: tb/bank_addr_gen_test.sv
module bank_addr_gen_test;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       acc_i = 1'b0;
  logic [6:0] fld_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [1:0] pwr_flags_i = 2'b11;
  logic [7:0] ram_rdata_i;
  logic [8:0] ram_addr_o;
  logic       ram_we_o;
  logic [7:0] rdata_o;

  int checks = 0;
  int errors = 0;

  // model state
  logic [7:0] m_stat = 8'h00;   // bits 4:3 unused in model
  logic [7:0] m_ptr  = 8'h00;

  always #(CLK_P/2) clk_i = ~clk_i;

  // RAM stand-in: data is a function of the address
  assign ram_rdata_i = ram_addr_o[7:0] ^ {7'h2D, ram_addr_o[8]};

  bank_addr_gen uut (.*);

  function automatic logic [8:0] exp_addr(input logic [6:0] f);
    logic [8:0] a;
    a = (f == 7'h00) ? {m_stat[7], m_ptr} : {m_stat[6:5], f};
    if (a[6:0] inside {7'h02, 7'h03, 7'h04, 7'h0A, 7'h0B}) a[8:7] = 2'b00;
    return a;
  endfunction

  function automatic logic [7:0] exp_stat();
    return {m_stat[7:5], pwr_flags_i, m_stat[2:0]};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [6:0] f);
    logic [8:0] a;
    a = exp_addr(f);
    if (a[6:0] == 7'h03) return exp_stat();
    if (a[6:0] == 7'h04) return m_ptr;
    if (f == 7'h00 && a[6:0] == 7'h00) return 8'h00;
    return a[7:0] ^ {7'h2D, a[8]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] f, input logic [7:0] d);
    logic [8:0] a;
    @(negedge clk_i);
    acc_i = 1'b1; we_i = 1'b1; fld_i = f; wdata_i = d;
    a = exp_addr(f);
    @(negedge clk_i);
    acc_i = 1'b0; we_i = 1'b0;
    if (a[6:0] == 7'h03) m_stat = d;
    else if (a[6:0] == 7'h04) m_ptr = d;
  endtask

  task automatic rd_chk(input string req, input logic [6:0] f);
    @(negedge clk_i);
    acc_i = 1'b1; we_i = 1'b0; fld_i = f;
    #1;
    chk(req, int'(ram_addr_o), int'(exp_addr(f)));
    chk(req, int'(rdata_o), int'(exp_rd(f)));
    chk(req, int'(ram_we_o), 0);
    acc_i = 1'b0;
  endtask

  task automatic we_chk(input string req, input logic [6:0] f, input logic exp_we);
    @(negedge clk_i);
    acc_i = 1'b1; we_i = 1'b1; fld_i = f; wdata_i = 8'hC3;
    #1;
    chk(req, int'(ram_we_o), int'(exp_we));
    chk(req, int'(ram_addr_o), int'(exp_addr(f)));
    acc_i = 1'b0; we_i = 1'b0;
    if (exp_addr(f) == 9'h003) m_stat = 8'hC3;
    if (exp_addr(f) == 9'h004) m_ptr = 8'hC3;
  endtask

  task automatic t_reset();
    rd_chk("R7 status", 7'h03);
    chk("R7 status value", int'(rdata_o), 8'h18);
    rd_chk("R7 pointer", 7'h04);
    chk("R7 pointer value", int'(rdata_o), 8'h00);
    rd_chk("R7 bank0", 7'h25);
  endtask

  task automatic t_direct();
    for (int b = 0; b < 4; b++) begin
      wr(7'h03, 8'(b << 5));
      rd_chk("R1 direct", 7'h25);
      rd_chk("R9 ram data", 7'h7F);
    end
    chk("R1 bank3 addr", int'(ram_addr_o), 9'h1FF);
  endtask

  task automatic t_indirect();
    wr(7'h04, 8'h34);
    wr(7'h03, 8'h80);
    rd_chk("R2 irp1", 7'h00);
    chk("R2 irp1 addr", int'(ram_addr_o), 9'h134);
    we_chk("R2 R8 indirect write", 7'h00, 1'b1);
    wr(7'h03, 8'h60);
    rd_chk("R2 irp0", 7'h00);
    chk("R2 irp0 addr", int'(ram_addr_o), 9'h034);
  endtask

  task automatic t_null();
    wr(7'h04, 8'h00);
    rd_chk("R3 null ptr0", 7'h00);
    we_chk("R3 null write", 7'h00, 1'b0);
    wr(7'h04, 8'h80);
    wr(7'h03, 8'h80);
    rd_chk("R3 null bank3", 7'h00);
    chk("R3 null rdata", int'(rdata_o), 0);
    we_chk("R3 null write hi", 7'h00, 1'b0);
  endtask

  task automatic t_core();
    wr(7'h03, 8'h40);
    wr(7'h04, 8'h5A);
    rd_chk("R4 ptr from bank2", 7'h04);
    chk("R4 ptr value", int'(rdata_o), 8'h5A);
    wr(7'h04, 8'h83);
    rd_chk("R4 status via ptr", 7'h00);
    chk("R4 status via ptr value", int'(rdata_o), 8'h58);
    we_chk("R4 no ram write status", 7'h03, 1'b0);
    we_chk("R4 no ram write ptr", 7'h04, 1'b0);
  endtask

  task automatic t_shared();
    wr(7'h03, 8'h60);
    rd_chk("R6 fold 02", 7'h02);
    chk("R6 fold 02 addr", int'(ram_addr_o), 9'h002);
    rd_chk("R6 fold 0A", 7'h0A);
    rd_chk("R6 fold 0B", 7'h0B);
    rd_chk("R6 no fold 0C", 7'h0C);
    chk("R6 0C addr", int'(ram_addr_o), 9'h18C);
    we_chk("R8 shared write", 7'h0B, 1'b1);
  endtask

  task automatic t_ro();
    pwr_flags_i = 2'b01;
    wr(7'h03, 8'hFF);
    rd_chk("R5 ro bits", 7'h03);
    chk("R5 ro value", int'(rdata_o), 8'hEF);
    pwr_flags_i = 2'b10;
    rd_chk("R5 flag follow", 7'h03);
    chk("R5 flag follow value", int'(rdata_o), 8'hF7);
    wr(7'h03, 8'h18);
    rd_chk("R5 write ignored", 7'h03);
    chk("R5 write ignored value", int'(rdata_o), 8'h10);
  endtask

  task automatic t_noacc();
    wr(7'h04, 8'h21);
    @(negedge clk_i);
    acc_i = 1'b0; we_i = 1'b1; fld_i = 7'h04; wdata_i = 8'h99;
    #1 chk("R8 no strobe", int'(ram_we_o), 0);
    @(negedge clk_i);
    acc_i = 1'b1; we_i = 1'b0; fld_i = 7'h04; wdata_i = 8'h77;
    @(negedge clk_i);
    acc_i = 1'b0; we_i = 1'b0;
    rd_chk("R10 ptr held", 7'h04);
    chk("R10 ptr value", int'(rdata_o), 8'h21);
    we_chk("R8 ordinary write", 7'h30, 1'b1);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_direct();
    t_indirect();
    t_null();
    t_core();
    t_shared();
    t_ro();
    t_noacc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule